// File: doc/BRIEF.md
# Knock front-end SPI configuration slave

This block is the digital control port of an engine-knock signal conditioning front end. A host processor writes 8-bit command words over a four-wire serial bus. Each completed word updates one control field: the sensor channel select, the programmable gain step, the bandpass centre step, the integrator time-constant step, or the clock prescaler setting together with a serial-output disable bit. The analog filter, rectifier and integrator read these fields directly. Any single word can switch the sensor channel, so the channel can change between two firing cycles.

All serial pins are sampled in the system clock domain through a synchronizer chain, and SCK edges are found there. A word is accepted only when chip select rises after exactly eight falling SCK edges. While a word is being written, the serial output plays back the last accepted word, most-significant bit first, which lets the host confirm each write. The serial output stays high-impedance when chip select is high or when the disable bit is set. The active-low diagnostic pin forces the output on in every case. The integrate/hold pin is synchronized and passed on as the integrator mode.

Top module: `knock_spi_cfg`

## Requirements
- R1: Input data is captured on each falling SCK edge while chip select is low, most-significant bit first. A word commits to a register when chip select rises after exactly 8 falling edges.
- R2: A transfer with fewer or more than 8 falling SCK edges changes no register and does not replace the word played back on the serial output.
- R3: While chip select is high and the diagnostic pin is high, the output enable is 0. SCK and data activity in that state changes no register.
- R4: While the diagnostic pin is low, the output enable is 1 whatever the state of chip select and the disable bit.
- R5: A disable bit of 1 keeps the output enable at 0 while chip select is low. A disable bit of 0 lets it go to 1 while chip select is low.
- R6: Command decode on bits [7:6]: 00 loads the bandpass step from [5:0]. 01 loads the gain step from [5:0]. 10 loads the time-constant step from [4:0], and bit 5 is ignored. 11 with bit 5 = 0 loads the prescaler from [4:1] and the disable bit from [0]. 11 with bit 5 = 1 loads the channel select from [0].
- R7: After reset every field is 0, the output enable is 0, the serial output data is 0 and the integrator mode is hold (0).
- R8: During a transfer the serial output presents the last committed word. Bit 7 appears from the fall of chip select, and the next bit appears after each rising SCK edge that follows a falling edge.
- R9: The integrator mode output is 1 (integrate) while the integrate/hold input is high and 0 (hold) while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| diag_n | input | 1 | Active-low diagnostic override of output enable |
| int_hold_in | input | 1 | Integrate (1) / hold (0) request |
| spi_so | output | 1 | Serial data out, for the pad buffer |
| spi_so_oe | output | 1 | Serial output enable, for the pad buffer |
| chan_sel | output | 1 | Sensor channel select |
| gain_step | output | 6 | Gain step |
| bpf_step | output | 6 | Bandpass step |
| tc_step | output | 5 | Integrator time-constant step |
| presc_sel | output | 4 | Clock prescaler setting |
| int_mode | output | 1 | Integrator mode, 1 integrate, 0 hold |

## Verification
With two synchronizer stages, a change on chip select, the diagnostic pin or the integrate/hold pin reaches the output enable and the integrator mode after two clock edges. Control fields update on the third edge after chip select rises, and the serial output data moves on the third edge after an SCK edge. The bench holds every SCK phase and every chip-select gap for six system clocks. It samples outputs on the falling system clock edge at the end of each phase, so every result has settled before it is compared. The playback bits are read at the end of each SCK high phase, as a host would read them before the next falling edge.

// File: rtl/knock_spi_pkg.sv
package knock_spi_pkg;
   localparam int WORD_W  = 8;
   localparam int FLD_W   = WORD_W - 2;
   localparam int TC_W    = FLD_W - 1;
   localparam int PRESC_W = FLD_W - 2;
   localparam int CNT_W   = $clog2(WORD_W + 2);

   typedef enum logic [1:0] {
      SEL_BPF  = 2'b00,
      SEL_GAIN = 2'b01,
      SEL_TC   = 2'b10,
      SEL_SYS  = 2'b11
   } sel_e;
endpackage

// File: rtl/knock_spi_sync.sv
module knock_spi_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("knock_spi_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("knock_spi_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/knock_spi_edge.sv
module knock_spi_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_s,
   input  logic cs_s,
   output logic sck_fall,
   output logic sck_rise,
   output logic cs_fall,
   output logic cs_rise
);
   logic sck_d, cs_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         cs_d  <= 1'b1;
      end else begin
         sck_d <= sck_s;
         cs_d  <= cs_s;
      end
   end

   assign sck_fall = sck_d & ~sck_s;
   assign sck_rise = ~sck_d & sck_s;
   assign cs_fall  = cs_d & ~cs_s;
   assign cs_rise  = ~cs_d & cs_s;
endmodule

// File: rtl/knock_spi_shifter.sv
module knock_spi_shifter import knock_spi_pkg::*; (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              mosi_s,
   input  logic              sck_fall,
   input  logic              sck_rise,
   input  logic              cs_fall,
   input  logic              cs_rise,
   output logic              commit,
   output logic [WORD_W-1:0] word,
   output logic              so_bit
);
   localparam logic [CNT_W-1:0] FULL  = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WORD_W + 1);

   logic [WORD_W-1:0] rx_q, tx_q, last_q;
   logic [CNT_W-1:0]  cnt_q;

   assign commit = cs_rise && (cnt_q == FULL);
   assign word   = rx_q;
   assign so_bit = tx_q[WORD_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q   <= '0;
         tx_q   <= '0;
         last_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (cs_fall) begin
            cnt_q <= '0;
            tx_q  <= last_q;
         end else if (!cs_s) begin
            if (sck_fall) begin
               rx_q <= {rx_q[WORD_W-2:0], mosi_s};
               if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
            end
            if (sck_rise && (cnt_q != '0)) begin
               tx_q <= {tx_q[WORD_W-2:0], 1'b0};
            end
         end
         if (commit) last_q <= rx_q;
      end
   end
endmodule

// File: rtl/knock_spi_regs.sv
module knock_spi_regs import knock_spi_pkg::*; #(
   parameter logic [FLD_W-1:0]   GAIN_RST  = '0,
   parameter logic [FLD_W-1:0]   BPF_RST   = '0,
   parameter logic [TC_W-1:0]    TC_RST    = '0,
   parameter logic [PRESC_W-1:0] PRESC_RST = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               commit,
   input  logic [WORD_W-1:0]  word,
   output logic               chan_sel,
   output logic [FLD_W-1:0]   gain_step,
   output logic [FLD_W-1:0]   bpf_step,
   output logic [TC_W-1:0]    tc_step,
   output logic [PRESC_W-1:0] presc_sel,
   output logic               so_dis
);
   sel_e sel;
   assign sel = sel_e'(word[WORD_W-1 -: 2]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_sel  <= 1'b0;
         gain_step <= GAIN_RST;
         bpf_step  <= BPF_RST;
         tc_step   <= TC_RST;
         presc_sel <= PRESC_RST;
         so_dis    <= 1'b0;
      end else if (commit) begin
         unique case (sel)
            SEL_BPF:  bpf_step  <= word[FLD_W-1:0];
            SEL_GAIN: gain_step <= word[FLD_W-1:0];
            SEL_TC:   tc_step   <= word[TC_W-1:0];
            SEL_SYS: begin
               if (word[FLD_W-1]) begin
                  chan_sel <= word[0];
               end else begin
                  presc_sel <= word[PRESC_W:1];
                  so_dis    <= word[0];
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/knock_spi_cfg.sv
module knock_spi_cfg import knock_spi_pkg::*; #(
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               spi_sck,
   input  logic               spi_cs_n,
   input  logic               spi_mosi,
   input  logic               diag_n,
   input  logic               int_hold_in,
   output logic               spi_so,
   output logic               spi_so_oe,
   output logic               chan_sel,
   output logic [FLD_W-1:0]   gain_step,
   output logic [FLD_W-1:0]   bpf_step,
   output logic [TC_W-1:0]    tc_step,
   output logic [PRESC_W-1:0] presc_sel,
   output logic               int_mode
);
   localparam int N_SYNC = 5;
   localparam logic [N_SYNC-1:0] SYNC_RST = 5'b01001;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("knock_spi_cfg: SYNC_STAGES must be at least 2");
   end

   logic ih_s, diag_s, mosi_s, sck_s, cs_s;
   logic sck_fall, sck_rise, cs_fall, cs_rise;
   logic commit, so_dis;
   logic [WORD_W-1:0] word;

   knock_spi_sync #(
      .WIDTH   (N_SYNC),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({int_hold_in, diag_n, spi_mosi, spi_sck, spi_cs_n}),
      .q     ({ih_s, diag_s, mosi_s, sck_s, cs_s})
   );

   knock_spi_edge i_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck_s    (sck_s),
      .cs_s     (cs_s),
      .sck_fall (sck_fall),
      .sck_rise (sck_rise),
      .cs_fall  (cs_fall),
      .cs_rise  (cs_rise)
   );

   knock_spi_shifter i_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_s     (cs_s),
      .mosi_s   (mosi_s),
      .sck_fall (sck_fall),
      .sck_rise (sck_rise),
      .cs_fall  (cs_fall),
      .cs_rise  (cs_rise),
      .commit   (commit),
      .word     (word),
      .so_bit   (spi_so)
   );

   knock_spi_regs i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit    (commit),
      .word      (word),
      .chan_sel  (chan_sel),
      .gain_step (gain_step),
      .bpf_step  (bpf_step),
      .tc_step   (tc_step),
      .presc_sel (presc_sel),
      .so_dis    (so_dis)
   );

   assign spi_so_oe = ~diag_s | (~cs_s & ~so_dis);
   assign int_mode  = ih_s;
endmodule

// File: rtl/knock_spi_chk.sv
module knock_spi_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        diag_s,
   input logic        cs_s,
   input logic        so_dis,
   input logic        so_oe,
   input logic        so,
   input logic        sck_rise,
   input logic        cs_fall,
   input logic        commit,
   input logic [22:0] cfg
);
   // R4: diagnostic pin low forces the output on
   a_r4_diag_forces_oe: assert property (@(posedge clk) disable iff (!rst_n)
      !diag_s |-> so_oe);

   // R3: deselected and not in diagnostic mode means no drive
   a_r3_cs_high_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_s && diag_s) |-> !so_oe);

   // R5: programmed disable bit wins over chip select
   a_r5_disable_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (so_dis && diag_s) |-> !so_oe);

   // R2: no field moves without a committed word
   a_r2_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(cfg));

   // R8: output data only moves after an SCK rise or a chip-select fall
   a_r8_so_moves_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      !(sck_rise || cs_fall) |=> $stable(so));
endmodule

bind knock_spi_cfg knock_spi_chk i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .diag_s   (diag_s),
   .cs_s     (cs_s),
   .so_dis   (so_dis),
   .so_oe    (spi_so_oe),
   .so       (spi_so),
   .sck_rise (sck_rise),
   .cs_fall  (cs_fall),
   .commit   (commit),
   .cfg      ({chan_sel, gain_step, bpf_step, tc_step, presc_sel, so_dis})
);

// File: tb/test_knock_spi_cfg.sv
module test_knock_spi_cfg;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, diag_n = 1'b1, ih = 1'b0;
   logic so, so_oe, chan;
   logic [5:0] gain, bpf;
   logic [4:0] tc;
   logic [3:0] presc;
   logic mode;
   int n_chk = 0, n_fail = 0;
   logic oe_mid;
   logic [7:0] rx;
   bit done = 0;

   always #10 clk = ~clk;

   knock_spi_cfg i_knock_spi_cfg (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
      .diag_n(diag_n), .int_hold_in(ih), .spi_so(so), .spi_so_oe(so_oe),
      .chan_sel(chan), .gain_step(gain), .bpf_step(bpf), .tc_step(tc),
      .presc_sel(presc), .int_mode(mode)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic half();
      repeat (6) @(negedge clk);
   endtask

   task automatic xfer(input logic [7:0] w, input int nbits);
      cs_n = 1'b0;
      half();
      oe_mid = so_oe;
      for (int i = 0; i < nbits; i++) begin
         sck = 1'b1;
         mosi = (i < 8) ? w[7-i] : 1'b0;
         half();
         if (i < 8) rx[7-i] = so;
         sck = 1'b0;
         half();
      end
      cs_n = 1'b1;
      half();
      half();
   endtask

   task automatic t_reset();
      chk("R7 gain", gain, 0);  chk("R7 bpf", bpf, 0);
      chk("R7 tc", tc, 0);      chk("R7 presc", presc, 0);
      chk("R7 chan", chan, 0);  chk("R7 oe", so_oe, 0);
      chk("R7 so", so, 0);      chk("R7 mode", mode, 0);
   endtask

   task automatic t_fields();
      xfer(8'h6A, 8); chk("R6 gain", gain, 42);
      chk("R8 loopback after reset", rx, 8'h00);
      xfer(8'h15, 8); chk("R6 bpf", bpf, 21);
      chk("R8 loopback gain word", rx, 8'h6A);
      xfer(8'h93, 8); chk("R6 tc", tc, 19);
      xfer(8'hA7, 8); chk("R6 tc bit5 ignored", tc, 7);
      chk("R1 msb first loopback", rx, 8'h93);
      xfer(8'hE1, 8); chk("R6 chan 1", chan, 1);
      chk("R6 chan word leaves presc", presc, 0);
      xfer(8'hD4, 8); chk("R6 presc", presc, 10);
      chk("R6 presc word leaves chan", chan, 1);
      xfer(8'hE0, 8); chk("R6 chan 0", chan, 0);
      chk("R8 loopback presc word", rx, 8'hD4);
      chk("R1 other fields kept", gain, 42);
   endtask

   task automatic t_partial();
      xfer(8'h7F, 5); chk("R2 short word gain", gain, 42);
      xfer(8'h7F, 9); chk("R2 long word gain", gain, 42);
      xfer(8'h3C, 8); chk("R2 loopback kept", rx, 8'hE0);
      chk("R1 commit after discard", bpf, 60);
   endtask

   task automatic t_cs_high();
      for (int i = 0; i < 8; i++) begin
         sck = 1'b1; mosi = 1'b1; half();
         chk("R3 oe with cs high", so_oe, 0);
         sck = 1'b0; half();
      end
      cs_n = 1'b0; half(); cs_n = 1'b1; half(); half();
      chk("R3 bpf untouched", bpf, 60);
      chk("R3 gain untouched", gain, 42);
      xfer(8'h55, 8); chk("R3 loopback untouched", rx, 8'h3C);
   endtask

   task automatic t_disable();
      xfer(8'hC0, 8); chk("R5 enabled with bit 0", oe_mid, 1);
      xfer(8'hC1, 8);
      xfer(8'h45, 8); chk("R5 disabled with bit 1", oe_mid, 0);
      chk("R1 commit while disabled", gain, 5);
      diag_n = 1'b0;
      xfer(8'h46, 8); chk("R4 diag beats disable", oe_mid, 1);
      diag_n = 1'b1;
      xfer(8'hC0, 8); chk("R5 still disabled", oe_mid, 0);
      xfer(8'h47, 8); chk("R5 re-enabled", oe_mid, 1);
   endtask

   task automatic t_diag();
      diag_n = 1'b0; repeat (4) @(negedge clk);
      chk("R4 diag with cs high", so_oe, 1);
      diag_n = 1'b1; repeat (4) @(negedge clk);
      chk("R3 oe after diag release", so_oe, 0);
   endtask

   task automatic t_inthold();
      ih = 1'b1; repeat (4) @(negedge clk);
      chk("R9 integrate", mode, 1);
      ih = 1'b0; repeat (4) @(negedge clk);
      chk("R9 hold", mode, 0);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_fields();
      t_partial();
      t_cs_high();
      t_disable();
      t_diag();
      t_inthold();
      done = 1;
      summary();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end
endmodule